// File: doc/BRIEF.md
# Stereo Transmit Sample FIFO

This block sits between a register bus and an audio serializer. Software writes the two halves of a stereo sample as separate register writes: a left word, then a right word. The right write joins the held left word and queues the pair as one entry in an eight-deep FIFO. The serializer pulls entries with a single-cycle pop request. The entry appears on the sample outputs, with a valid strobe, one cycle later.

A status word shows the fill count, empty and full, and two sticky error flags. One flag marks a pair that was dropped because the FIFO was full. The other marks a pop that found the FIFO empty. One interrupt line covers two conditions: the FIFO has drained to a level that software picks (at most half full, or completely empty), and an underflow has happened. A channel enable register clears the FIFO state when it is written with zero. Data writes are still accepted while the channel is stopped, so software can prefill the FIFO (for example with silence) and then restart the channel cleanly.

Top module: `stereo_tx_fifo`

## Requirements
- R1: Out of reset: status word 16'h2000 (only the empty flag set), interrupt low, sample valid low, channel stopped, control bits zero.
- R2: A write to address 0x10 holds a left word and does not change the fill count. A following write to 0x14 commits the pair {left, right} and raises the count by one. A write to 0x14 with no left word held is ignored.
- R3: The FIFO holds DEPTH (8) entries. Status bit 12 is set while the count equals DEPTH. A pair committed while full is dropped and sets sticky status bit 14.
- R4: A pop while the channel runs and the FIFO is not empty drives sample valid high in the next cycle, with that entry's left and right words, in first-in first-out order.
- R5: A pop while the channel runs and the FIFO is empty leaves sample valid low and sets sticky status bit 15.
- R6: A pop while the channel is stopped is ignored: no valid, no count change, no underflow flag.
- R7: A commit and a pop in the same cycle both take effect. The count is unchanged when the FIFO is neither empty nor full. When empty, the pop underflows and the entry is kept. When full, the pair is dropped and the pop still succeeds.
- R8: Any write to the enable register at 0x24 clears status bits 14 and 15. Writing bit0 = 0 stops the channel and empties the FIFO, including any held left word. Writing bit0 = 1 runs the channel and keeps the stored entries.
- R9: The control register at 0x20 holds bit0 (level: 0 = count <= DEPTH/2, 1 = count == 0) and bit1 (interrupt enable). The interrupt is high one cycle after the registered state shows the channel running, bit1 set, and either the level condition or the underflow flag.
- R10: Status bits [3:0] carry the fill count. Bit 13 is set exactly when the count is zero. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register byte address |
| wr_data_i | input | 32 | Register write data |
| pop_i | input | 1 | Serializer request for the next entry |
| sample_left_o | output | 32 | Left word of the popped entry |
| sample_right_o | output | 32 | Right word of the popped entry |
| sample_valid_o | output | 1 | Sample outputs carry a popped entry this cycle |
| status_o | output | 16 | Fill count, empty, full, overflow and underflow flags |
| irq_o | output | 1 | Level or underflow interrupt |

## Verification
The interesting collision is a right-word commit and a serializer pop landing in the same clock. The bench provokes it at every fill level from empty to full by preloading that many pairs, writing the left word, and then issuing the right write and the pop in one cycle. A queue model in the bench predicts the outcome. At empty, the pop must underflow while the new pair is kept. At full, the pair must be dropped with the overflow flag while the pop returns the old head. At every level between, the count must stay put and the later drain must return all entries in order.

// File: rtl/stfifo_pkg.sv
package stfifo_pkg;
  localparam int REG_AW = 8;
  localparam logic [REG_AW-1:0] ADR_LEFT  = 8'h10;
  localparam logic [REG_AW-1:0] ADR_RIGHT = 8'h14;
  localparam logic [REG_AW-1:0] ADR_CTRL  = 8'h20;
  localparam logic [REG_AW-1:0] ADR_ENA   = 8'h24;

  localparam int STAT_W   = 16;
  localparam int ST_FULL  = 12;
  localparam int ST_EMPTY = 13;
  localparam int ST_OVF   = 14;
  localparam int ST_UNF   = 15;

  typedef struct packed {
    logic irq_en;     // control bit1
    logic lvl_empty;  // control bit0
  } tx_ctrl_t;
endpackage

// File: rtl/stfifo_ctrl_regs.sv
module stfifo_ctrl_regs
  import stfifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [1:0]        wr_bits,
  output tx_ctrl_t          ctrl_q,
  output logic              run_q,
  output logic              ena_wr,
  output logic              flush
);
  logic ctrl_wr;

  assign ctrl_wr = wr_en && (wr_addr == ADR_CTRL);
  assign ena_wr  = wr_en && (wr_addr == ADR_ENA);
  assign flush   = ena_wr && !wr_bits[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      run_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.irq_en    <= wr_bits[1];
        ctrl_q.lvl_empty <= wr_bits[0];
      end
      if (ena_wr) run_q <= wr_bits[0];
    end
  end
endmodule

// File: rtl/stfifo_pair_asm.sv
module stfifo_pair_asm
  import stfifo_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              flush,
  output logic              push,
  output logic [2*DW-1:0]   push_pair
);
  logic [DW-1:0] left_q;
  logic          held_q;
  logic          left_wr, right_wr;

  assign left_wr   = wr_en && (wr_addr == ADR_LEFT);
  assign right_wr  = wr_en && (wr_addr == ADR_RIGHT);
  assign push      = right_wr && held_q;
  assign push_pair = {left_q, wr_data};

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      held_q <= 1'b0;
    end else if (left_wr) begin
      held_q <= 1'b1;
    end else if (right_wr) begin
      held_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (left_wr) left_q <= wr_data;
  end
endmodule

// File: rtl/stfifo_store.sv
module stfifo_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int EW   = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [EW-1:0] push_pair,
  input  logic          pop,
  input  logic          run,
  output logic [CW-1:0] count_q,
  output logic [EW-1:0] rd_pair_q,
  output logic          rd_valid_q,
  output logic          push_drop,
  output logic          pop_miss
);
  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic          full, empty, do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full      = (count_q == CW'(DEPTH));
  assign empty     = (count_q == '0);
  assign do_push   = push && !full;
  assign do_pop    = pop && run && !empty;
  assign push_drop = push && full;
  assign pop_miss  = pop && run && empty;

  // storage array: no reset, synchronous read, suitable for block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= push_pair;
  end

  always_ff @(posedge clk) begin
    if (do_pop) rd_pair_q <= mem[rptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr_q     <= '0;
      rptr_q     <= '0;
      count_q    <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= do_pop;
      if (do_push) wptr_q <= bump(wptr_q);
      if (do_pop)  rptr_q <= bump(rptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end
endmodule

// File: rtl/stfifo_irq_status.sv
module stfifo_irq_status
  import stfifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ena_wr,
  input  logic              push_drop,
  input  logic              pop_miss,
  input  logic              run,
  input  tx_ctrl_t          ctrl,
  input  logic [CW-1:0]     count,
  output logic [STAT_W-1:0] status,
  output logic              irq_q
);
  logic ovf_q, unf_q, lvl_hit;

  always_ff @(posedge clk) begin
    if (rst || ena_wr) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_q | push_drop;
      unf_q <= unf_q | pop_miss;
    end
  end

  assign lvl_hit = ctrl.lvl_empty ? (count == '0) : (count <= CW'(DEPTH / 2));

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= run && ctrl.irq_en && (lvl_hit || unf_q);
  end

  always_comb begin
    status           = '0;
    status[CW-1:0]   = count;
    status[ST_FULL]  = (count == CW'(DEPTH));
    status[ST_EMPTY] = (count == '0);
    status[ST_OVF]   = ovf_q;
    status[ST_UNF]   = unf_q;
  end
endmodule

// File: rtl/stereo_tx_fifo.sv
module stereo_tx_fifo
  import stfifo_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              pop_i,
  output logic [DW-1:0]     sample_left_o,
  output logic [DW-1:0]     sample_right_o,
  output logic              sample_valid_o,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);
  tx_ctrl_t        ctrl;
  logic            run, ena_wr, flush, push, push_drop, pop_miss;
  logic [2*DW-1:0] push_pair, rd_pair;
  logic [CW-1:0]   count;

  stfifo_ctrl_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_bits(wr_data_i[1:0]), .ctrl_q(ctrl), .run_q(run),
    .ena_wr(ena_wr), .flush(flush)
  );

  stfifo_pair_asm #(.DW(DW)) u_pair (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .flush(flush), .push(push), .push_pair(push_pair)
  );

  stfifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .flush(flush), .push(push), .push_pair(push_pair),
    .pop(pop_i), .run(run), .count_q(count), .rd_pair_q(rd_pair),
    .rd_valid_q(sample_valid_o), .push_drop(push_drop), .pop_miss(pop_miss)
  );

  stfifo_irq_status #(.DEPTH(DEPTH)) u_stat (
    .clk(clk), .rst(rst), .ena_wr(ena_wr), .push_drop(push_drop),
    .pop_miss(pop_miss), .run(run), .ctrl(ctrl), .count(count),
    .status(status_o), .irq_q(irq_o)
  );

  assign sample_left_o  = rd_pair[2*DW-1:DW];
  assign sample_right_o = rd_pair[DW-1:0];
endmodule

// File: rtl/stereo_tx_fifo_chk.sv
module stereo_tx_fifo_chk
  import stfifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_i,
  input logic [REG_AW-1:0] wr_addr_i,
  input logic              pop_i,
  input logic              sample_valid_o,
  input logic [STAT_W-1:0] status_o,
  input logic              irq_o,
  input logic              run,
  input logic              irq_en
);
  logic ena_touch, right_touch;
  assign ena_touch   = wr_en_i && (wr_addr_i == ADR_ENA);
  assign right_touch = wr_en_i && (wr_addr_i == ADR_RIGHT);

  a_r3_fill_bound: assert property (@(posedge clk) disable iff (rst)
    int'(status_o[CW-1:0]) <= DEPTH);

  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (status_o[ST_OVF] && !ena_touch) |=> status_o[ST_OVF]);

  a_r5_unf_sticky: assert property (@(posedge clk) disable iff (rst)
    (status_o[ST_UNF] && !ena_touch) |=> status_o[ST_UNF]);

  a_r4_valid_needs_pop: assert property (@(posedge clk) disable iff (rst)
    sample_valid_o |-> $past(pop_i && run));

  a_r2_grow_on_right: assert property (@(posedge clk) disable iff (rst)
    (int'(status_o[CW-1:0]) > int'($past(status_o[CW-1:0]))) |-> $past(right_touch));

  a_r6_shrink_cause: assert property (@(posedge clk) disable iff (rst)
    (int'(status_o[CW-1:0]) < int'($past(status_o[CW-1:0])))
      |-> $past((pop_i && run) || ena_touch));

  a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(run && irq_en));
endmodule

bind stereo_tx_fifo stereo_tx_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .pop_i(pop_i), .sample_valid_o(sample_valid_o), .status_o(status_o),
  .irq_o(irq_o), .run(run), .irq_en(ctrl.irq_en)
);

// File: tb/stereo_tx_fifo_tb.sv
`timescale 1ns/1ps
module stereo_tx_fifo_tb;
  localparam int DEPTH = 8;
  localparam logic [7:0] A_L = 8'h10, A_R = 8'h14, A_C = 8'h20, A_E = 8'h24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        pop = 1'b0;
  logic [31:0] s_left, s_right;
  logic        s_valid, irq;
  logic [15:0] status;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stereo_tx_fifo u_dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pop_i(pop), .sample_left_o(s_left),
    .sample_right_o(s_right), .sample_valid_o(s_valid),
    .status_o(status), .irq_o(irq)
  );

  // bench model
  logic [63:0] q[$];
  logic        m_en = 0, m_lvl = 0, m_ie = 0, m_ovf = 0, m_unf = 0, m_held = 0;
  logic [31:0] m_left = '0;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input string req, input logic we, input logic [7:0] a,
                     input logic [31:0] d, input logic p);
    logic        e_irq, e_v;
    logic [63:0] e_pair;
    logic [15:0] e_st;
    bit          full_pre, empty_pre;
    wr_en = we; wr_addr = a; wr_data = d; pop = p;
    e_irq = m_en && m_ie && (m_unf || (m_lvl ? (q.size() == 0) : (q.size() <= DEPTH/2)));
    full_pre  = (q.size() == DEPTH);
    empty_pre = (q.size() == 0);
    e_v = 1'b0; e_pair = '0;
    if (we) begin
      case (a)
        A_L: begin m_left = d; m_held = 1; end
        A_R: if (m_held) begin
               if (full_pre) m_ovf = 1; else q.push_back({m_left, d});
               m_held = 0;
             end
        A_C: begin m_lvl = d[0]; m_ie = d[1]; end
        A_E: begin
               m_ovf = 0; m_unf = 0; m_en = d[0];
               if (!d[0]) begin q.delete(); m_held = 0; end
             end
        default: ;
      endcase
    end
    if (p && m_en) begin
      if (!empty_pre) begin e_v = 1; e_pair = q.pop_front(); end
      else m_unf = 1;
    end
    e_st = {m_unf, m_ovf, q.size() == 0, q.size() == DEPTH, 8'h00, 4'(q.size())};
    @(negedge clk);
    check(req, "status", 64'(status), 64'(e_st));
    check(req, "valid", 64'(s_valid), 64'(e_v));
    if (e_v) check(req, "pair", {s_left, s_right}, e_pair);
    check(req, "irq", 64'(irq), 64'(e_irq));
    wr_en = 0; pop = 0;
  endtask

  function automatic logic [31:0] lw(input int n, input int i);
    return 32'hA000_0000 | (n << 8) | i;
  endfunction
  function automatic logic [31:0] rw(input int n, input int i);
    return 32'hB000_0000 | (n << 8) | i;
  endfunction

  task automatic idle(input string req);
    cyc(req, 0, 8'h00, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    idle("R1"); idle("R1 R10");
    cyc("R2 lone right ignored", 1, A_R, 32'h1234_5678, 0);
    cyc("R8 run", 1, A_E, 1, 0);
    cyc("R9 half level", 1, A_C, 2, 0);
    idle("R9");
    // fill sweep including one overflow
    for (int i = 0; i <= DEPTH; i++) begin
      cyc("R2 left holds", 1, A_L, lw(0, i), 0);
      cyc("R3 commit", 1, A_R, rw(0, i), 0);
      idle("R9 half level");
    end
    // drain with empty level; last pop underflows
    cyc("R9 empty level", 1, A_C, 3, 0);
    for (int i = 0; i <= DEPTH; i++) begin
      cyc("R4 R5 pop", 0, 8'h00, 0, 1);
      idle("R9 empty level");
    end
    cyc("R8 clear flags", 1, A_E, 1, 0);
    idle("R10");
    // stopped channel: writes accepted, pops ignored
    cyc("R8 stop", 1, A_E, 0, 0);
    for (int i = 0; i < 2; i++) begin
      cyc("R8 prefill", 1, A_L, lw(1, i), 0);
      cyc("R8 prefill", 1, A_R, rw(1, i), 0);
    end
    cyc("R6 pop stopped", 0, 8'h00, 0, 1);
    cyc("R6 pop stopped", 0, 8'h00, 0, 1);
    cyc("R8 restart keeps", 1, A_E, 1, 0);
    cyc("R4", 0, 8'h00, 0, 1);
    cyc("R4", 0, 8'h00, 0, 1);
    // held left word discarded by stop
    cyc("R8", 1, A_L, 32'hDEAD_0000, 0);
    cyc("R8 stop drops held", 1, A_E, 0, 0);
    cyc("R8", 1, A_E, 1, 0);
    cyc("R2 R8 right after stop", 1, A_R, 32'hDEAD_0001, 0);
    // commit and pop in the same cycle at every fill level
    for (int f = 0; f <= DEPTH; f++) begin
      cyc("R8", 1, A_E, 0, 0);
      cyc("R8", 1, A_E, 1, 0);
      for (int i = 0; i < f; i++) begin
        cyc("R2", 1, A_L, lw(2 + f, i), 0);
        cyc("R2", 1, A_R, rw(2 + f, i), 0);
      end
      cyc("R7", 1, A_L, lw(2 + f, 99), 0);
      cyc("R7 commit with pop", 1, A_R, rw(2 + f, 99), 1);
      for (int i = 0; i <= DEPTH; i++) cyc("R4 R7 drain", 0, 8'h00, 0, 1);
    end
    // silence fill while stopped until full, then restart
    cyc("R8", 1, A_E, 0, 0);
    for (int i = 0; i < DEPTH; i++) begin
      cyc("R8 silence", 1, A_L, 0, 0);
      cyc("R3 silence", 1, A_R, 0, 0);
    end
    cyc("R8 restart full", 1, A_E, 1, 0);
    idle("R3");
    cyc("R4", 0, 8'h00, 0, 1);
    idle("R9");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule